// File: doc/BRIEF.md
# Timer Output Flag Generator

This block turns the event pulses of one timer channel's counter into that channel's output pin level. A three-bit mode selects how the pin responds. It can follow the counter's active status. It can clear, set or toggle on a compare match. It can toggle on matches that alternate between two compare registers. It can set on a compare and clear on a secondary-input edge or on a counter rollover. It can also pass the primary count clock through while counting is active, which gives a gated clock.

The final level can be inverted. A debug input can force the pin low. When the channel is the master, it sends its compare event to the neighbouring channels one cycle later. When external forcing is enabled, a compare arriving from another channel loads a supplied value into the flag. The local compare, rollover and edge events are then ignored.

All inputs are level or single-cycle pulse signals sampled on the rising edge of the IP clock. There is no data stream and no handshake: every pin is plain control or status, and the block never stalls.

Top module: `oflag_gen`

## Requirements
- R1: After reset the internal flag is 0, the mode-4 alternation expects compare 1 first, and `cmp_bcast` is 0.
- R2: In mode 0 (code 3'd0) the pre-polarity level equals `count_active`. In mode 7 (code 3'd7) it equals `prim_clk & count_active`. Both follow the inputs with no register delay.
- R3: With local control, a `cmp_hit` pulse changes the flag on the next clock edge: to 0 in mode 1, to 1 in mode 2, and to its inverse in mode 3. In modes 1 to 6 the pin shows the flag.
- R4: In mode 4 the flag toggles first on `cmp1_hit`, then on `cmp2_hit`, and the two keep alternating. A pulse on the compare not currently expected changes nothing.
- R5: In mode 5 `cmp_hit` sets the flag and `sec_edge` clears it. In mode 6 `cmp_hit` sets the flag and `rollover` clears it. In both modes, a set and a clear in the same cycle give 0.
- R6: When `invert_out` is 1 the pin is the inverse of the pre-polarity level.
- R7: When `dbg_mode` is 1 and `dbg_action` is 2 or 3, the pin is 0 regardless of the other inputs. Actions 0 and 1 leave the pin unchanged.
- R8: When `force_en` is 1, an `ext_cmp` pulse loads `force_val` into the flag on the next edge. `cmp_hit`, `cmp1_hit`, `cmp2_hit`, `rollover` and `sec_edge` then have no effect on the flag or on the mode-4 alternation.
- R9: `cmp_bcast` is 1 for exactly the cycle after a cycle in which `master_en` and `cmp_hit` were both 1. Otherwise it is 0.
- R10: Changing the mode does not alter the stored flag. It keeps its value until an event of the new mode arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | IP clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_mode | input | 3 | Output mode code 0..7 |
| invert_out | input | 1 | Invert the final output |
| master_en | input | 1 | Broadcast local compare events |
| force_en | input | 1 | Let the external compare control the flag |
| force_val | input | 1 | Value loaded on an external compare |
| ext_cmp | input | 1 | Compare pulse from another channel |
| cmp_hit | input | 1 | Local compare match pulse |
| cmp1_hit | input | 1 | Compare-register-1 match pulse |
| cmp2_hit | input | 1 | Compare-register-2 match pulse |
| rollover | input | 1 | Counter rollover pulse |
| sec_edge | input | 1 | Secondary input edge pulse |
| count_active | input | 1 | Counter is counting |
| prim_clk | input | 1 | Primary count clock level |
| dbg_mode | input | 1 | Chip is in debug |
| dbg_action | input | 2 | Debug action code |
| flag_pin | output | 1 | Output flag pin |
| cmp_bcast | output | 1 | Registered compare broadcast |

## Verification
The assertions check on every cycle the rules that depend on one transition at a time. These are the set and clear effects of compare events, the rule that a clear wins in modes 5 and 6, the alternation step of mode 4, loading the forced value, the timing of the broadcast, and the debug force to low. Only the bench's scenarios can show longer behaviour. That includes sequences of several toggles, mode 4 ignoring the compare it is not expecting, the flag surviving a mode change, the local events having no effect while forcing is on, and the interplay of polarity with the combinational modes 0 and 7.

// File: rtl/oflag_pkg.sv
package oflag_pkg;
  localparam int MODE_W = 3;
  localparam int DBG_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    OM_ACTIVE   = 3'd0,
    OM_CLR      = 3'd1,
    OM_SET      = 3'd2,
    OM_TGL      = 3'd3,
    OM_ALT_TGL  = 3'd4,
    OM_SET_SEC  = 3'd5,
    OM_SET_ROLL = 3'd6,
    OM_GATED    = 3'd7
  } out_mode_e;
endpackage

// File: rtl/ofg_alt_track.sv
module ofg_alt_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cmp1_hit,
  input  logic cmp2_hit,
  output logic alt_hit
);
  logic expect2_q;

  assign alt_hit = enable & (expect2_q ? cmp2_hit : cmp1_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       expect2_q <= 1'b0;
    else if (alt_hit) expect2_q <= ~expect2_q;
  end

  // The pointer moves from compare 1 to compare 2 after a first-stage hit.
  assert_alt_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !expect2_q && cmp1_hit) |=> expect2_q);
  // A pulse on the compare not being expected leaves the pointer where it is.
  assert_alt_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && expect2_q && !cmp2_hit) |=> expect2_q);
endmodule

// File: rtl/ofg_flag_core.sv
module ofg_flag_core
  import oflag_pkg::*;
#(
  parameter logic RESET_FLAG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              force_en,
  input  logic              force_val,
  input  logic              ext_cmp,
  input  logic              cmp_hit,
  input  logic              alt_hit,
  input  logic              rollover,
  input  logic              sec_edge,
  output logic              flag_q
);
  logic flag_d;
  out_mode_e m;

  assign m = out_mode_e'(mode);

  always_comb begin
    flag_d = flag_q;
    if (force_en) begin
      if (ext_cmp) flag_d = force_val;
    end else begin
      unique case (m)
        OM_CLR:      if (cmp_hit) flag_d = 1'b0;
        OM_SET:      if (cmp_hit) flag_d = 1'b1;
        OM_TGL:      if (cmp_hit) flag_d = ~flag_q;
        OM_ALT_TGL:  if (alt_hit) flag_d = ~flag_q;
        OM_SET_SEC: begin
          if (sec_edge)     flag_d = 1'b0;
          else if (cmp_hit) flag_d = 1'b1;
        end
        OM_SET_ROLL: begin
          if (rollover)     flag_d = 1'b0;
          else if (cmp_hit) flag_d = 1'b1;
        end
        default: flag_d = flag_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= RESET_FLAG;
    else        flag_q <= flag_d;
  end

  assert_set_on_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en && mode == OM_SET && cmp_hit) |=> flag_q);
  assert_clr_on_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en && mode == OM_CLR && cmp_hit) |=> !flag_q);
  assert_clear_wins_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en && mode == OM_SET_SEC && sec_edge) |=> !flag_q);
  assert_clear_wins_roll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en && mode == OM_SET_ROLL && rollover) |=> !flag_q);
  assert_force_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en && ext_cmp) |=> (flag_q == $past(force_val)));
  assert_force_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en && !ext_cmp) |=> $stable(flag_q));
endmodule

// File: rtl/ofg_pin_drive.sv
module ofg_pin_drive
  import oflag_pkg::*;
(
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              flag_q,
  input  logic              count_active,
  input  logic              prim_clk,
  input  logic              invert_out,
  input  logic              dbg_mode,
  input  logic [DBG_W-1:0]  dbg_action,
  output logic              flag_pin
);
  logic raw_lvl;
  logic pol_lvl;
  logic dbg_low;

  always_comb begin
    unique case (out_mode_e'(mode))
      OM_ACTIVE: raw_lvl = count_active;
      OM_GATED:  raw_lvl = prim_clk & count_active;
      default:   raw_lvl = flag_q;
    endcase
  end

  assign pol_lvl  = raw_lvl ^ invert_out;
  assign dbg_low  = dbg_mode & dbg_action[1];
  assign flag_pin = dbg_low ? 1'b0 : pol_lvl;

  always_comb begin
    if (rst_n && dbg_mode && (dbg_action == 2'd2 || dbg_action == 2'd3))
      assert_dbg_low_R7: assert (flag_pin == 1'b0);
  end
endmodule

// File: rtl/oflag_gen.sv
module oflag_gen
  import oflag_pkg::*;
#(
  parameter logic RESET_FLAG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] out_mode,
  input  logic              invert_out,
  input  logic              master_en,
  input  logic              force_en,
  input  logic              force_val,
  input  logic              ext_cmp,
  input  logic              cmp_hit,
  input  logic              cmp1_hit,
  input  logic              cmp2_hit,
  input  logic              rollover,
  input  logic              sec_edge,
  input  logic              count_active,
  input  logic              prim_clk,
  input  logic              dbg_mode,
  input  logic [DBG_W-1:0]  dbg_action,
  output logic              flag_pin,
  output logic              cmp_bcast
);
  logic alt_en;
  logic alt_hit;
  logic flag_q;
  logic bcast_q;

  assign alt_en = !force_en && (out_mode == OM_ALT_TGL);

  ofg_alt_track u_alt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (alt_en),
    .cmp1_hit (cmp1_hit),
    .cmp2_hit (cmp2_hit),
    .alt_hit  (alt_hit)
  );

  ofg_flag_core #(.RESET_FLAG(RESET_FLAG)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (out_mode),
    .force_en  (force_en),
    .force_val (force_val),
    .ext_cmp   (ext_cmp),
    .cmp_hit   (cmp_hit),
    .alt_hit   (alt_hit),
    .rollover  (rollover),
    .sec_edge  (sec_edge),
    .flag_q    (flag_q)
  );

  ofg_pin_drive u_pin (
    .rst_n        (rst_n),
    .mode         (out_mode),
    .flag_q       (flag_q),
    .count_active (count_active),
    .prim_clk     (prim_clk),
    .invert_out   (invert_out),
    .dbg_mode     (dbg_mode),
    .dbg_action   (dbg_action),
    .flag_pin     (flag_pin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcast_q <= 1'b0;
    else        bcast_q <= master_en & cmp_hit;
  end

  assign cmp_bcast = bcast_q;

  assert_bcast_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_bcast |-> $past(master_en && cmp_hit));
  assert_bcast_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && cmp_hit) |=> cmp_bcast);
endmodule

// File: tb/oflag_gen_test.sv
module oflag_gen_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] out_mode = 3'd2;
  logic invert_out = 0, master_en = 0, force_en = 0, force_val = 0, ext_cmp = 0;
  logic cmp_hit = 0, cmp1_hit = 0, cmp2_hit = 0, rollover = 0, sec_edge = 0;
  logic count_active = 0, prim_clk = 0, dbg_mode = 0;
  logic [1:0] dbg_action = 2'd0;
  logic flag_pin, cmp_bcast;

  int checks = 0;
  int errors = 0;
  logic m_flag = 0, m_exp2 = 0, m_bcast = 0;

  oflag_gen uut (
    .clk(clk), .rst_n(rst_n), .out_mode(out_mode), .invert_out(invert_out),
    .master_en(master_en), .force_en(force_en), .force_val(force_val),
    .ext_cmp(ext_cmp), .cmp_hit(cmp_hit), .cmp1_hit(cmp1_hit),
    .cmp2_hit(cmp2_hit), .rollover(rollover), .sec_edge(sec_edge),
    .count_active(count_active), .prim_clk(prim_clk), .dbg_mode(dbg_mode),
    .dbg_action(dbg_action), .flag_pin(flag_pin), .cmp_bcast(cmp_bcast)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_pin();
    logic raw;
    if (out_mode == 3'd0)      raw = count_active;
    else if (out_mode == 3'd7) raw = prim_clk & count_active;
    else                       raw = m_flag;
    if (dbg_mode && dbg_action >= 2'd2) return 1'b0;
    return raw ^ invert_out;
  endfunction

  function automatic void model_edge();
    logic hit;
    m_bcast = master_en & cmp_hit;
    if (force_en) begin
      if (ext_cmp) m_flag = force_val;
    end else begin
      case (out_mode)
        3'd1: if (cmp_hit) m_flag = 1'b0;
        3'd2: if (cmp_hit) m_flag = 1'b1;
        3'd3: if (cmp_hit) m_flag = ~m_flag;
        3'd4: begin
          hit = m_exp2 ? cmp2_hit : cmp1_hit;
          if (hit) begin m_flag = ~m_flag; m_exp2 = ~m_exp2; end
        end
        3'd5: if (sec_edge) m_flag = 1'b0; else if (cmp_hit) m_flag = 1'b1;
        3'd6: if (rollover) m_flag = 1'b0; else if (cmp_hit) m_flag = 1'b1;
        default: ;
      endcase
    end
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet();
    cmp_hit = 0; cmp1_hit = 0; cmp2_hit = 0; rollover = 0; sec_edge = 0; ext_cmp = 0;
  endtask

  // One edge: model advances with the held inputs, then outputs are compared.
  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    #1;
    check({req, " pin"}, flag_pin, exp_pin());
    check({req, " bcast"}, cmp_bcast, m_bcast);
    quiet();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expected=finish actual=timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    // R1: reset state seen at the pins
    check("R1 pin in reset", flag_pin, 1'b0);
    check("R1 bcast in reset", cmp_bcast, 1'b0);
    @(negedge clk); rst_n = 1;
    step("R1 idle");

    // R3 set, clear, toggle
    out_mode = 3'd2; cmp_hit = 1; step("R3 set");
    check("R3 set level", flag_pin, 1'b1);
    out_mode = 3'd1; cmp_hit = 1; step("R3 clear");
    check("R3 clear level", flag_pin, 1'b0);
    out_mode = 3'd3; cmp_hit = 1; step("R3 toggle1");
    cmp_hit = 1; step("R3 toggle2");
    check("R3 toggle back", flag_pin, 1'b0);

    // R4 alternation: compare 2 ignored first, then 1, 1 ignored, then 2
    out_mode = 3'd4; cmp2_hit = 1; step("R4 wrong first");
    check("R4 cmp2 ignored", flag_pin, 1'b0);
    cmp1_hit = 1; step("R4 cmp1");
    check("R4 toggled by cmp1", flag_pin, 1'b1);
    cmp1_hit = 1; step("R4 cmp1 again");
    check("R4 cmp1 ignored", flag_pin, 1'b1);
    cmp2_hit = 1; step("R4 cmp2");
    check("R4 toggled by cmp2", flag_pin, 1'b0);

    // R5 set with clear on secondary edge / rollover, clear wins
    out_mode = 3'd5; cmp_hit = 1; step("R5 set sec");
    cmp_hit = 1; sec_edge = 1; step("R5 both sec");
    check("R5 clear wins sec", flag_pin, 1'b0);
    out_mode = 3'd6; cmp_hit = 1; step("R5 set roll");
    rollover = 1; step("R5 roll clear");
    check("R5 roll clears", flag_pin, 1'b0);
    cmp_hit = 1; step("R5 set roll2");
    cmp_hit = 1; rollover = 1; step("R5 both roll");
    check("R5 clear wins roll", flag_pin, 1'b0);

    // R10 mode change keeps flag
    out_mode = 3'd2; cmp_hit = 1; step("R10 set");
    out_mode = 3'd1; step("R10 change");
    check("R10 flag kept", flag_pin, 1'b1);

    // R6 polarity
    invert_out = 1; step("R6 invert");
    check("R6 inverted", flag_pin, 1'b0);
    invert_out = 0;

    // R7 debug actions
    dbg_mode = 1; dbg_action = 2'd1; step("R7 action1");
    check("R7 action1 no effect", flag_pin, 1'b1);
    dbg_action = 2'd2; step("R7 action2");
    check("R7 forced low", flag_pin, 1'b0);
    dbg_action = 2'd3; invert_out = 1; out_mode = 3'd0; step("R7 action3");
    check("R7 forced low inv", flag_pin, 1'b0);
    dbg_mode = 0; invert_out = 0; out_mode = 3'd1;

    // R8 external force
    force_en = 1; cmp_hit = 1; step("R8 local ignored");
    check("R8 cmp ignored", flag_pin, 1'b1);
    ext_cmp = 1; force_val = 0; step("R8 load0");
    check("R8 loaded 0", flag_pin, 1'b0);
    out_mode = 3'd4; cmp1_hit = 1; step("R8 alt frozen");
    force_en = 0; cmp2_hit = 1; step("R8 pointer kept");
    check("R8 alt still expects cmp1", flag_pin, 1'b0);

    // R9 broadcast
    out_mode = 3'd1; master_en = 1; cmp_hit = 1; step("R9 bcast");
    check("R9 bcast high", cmp_bcast, 1'b1);
    step("R9 bcast drop");
    check("R9 bcast low", cmp_bcast, 1'b0);
    master_en = 0; cmp_hit = 1; step("R9 no master");
    check("R9 bcast off", cmp_bcast, 1'b0);

    // R2 combinational modes
    out_mode = 3'd0; count_active = 1; #1;
    check("R2 active follows", flag_pin, 1'b1);
    out_mode = 3'd7; prim_clk = 0; #1;
    check("R2 gated low", flag_pin, 1'b0);
    prim_clk = 1; #1;
    check("R2 gated high", flag_pin, 1'b1);
    count_active = 0; #1;
    check("R2 gated stop", flag_pin, 1'b0);

    // Random mix across all requirements
    for (int i = 0; i < 3000; i++) begin
      out_mode = 3'($urandom_range(0, 7));
      invert_out = ($urandom_range(0, 7) == 0);
      master_en = $urandom_range(0, 1);
      force_en = ($urandom_range(0, 5) == 0);
      force_val = $urandom_range(0, 1);
      ext_cmp = ($urandom_range(0, 3) == 0);
      cmp_hit = ($urandom_range(0, 3) == 0);
      cmp1_hit = ($urandom_range(0, 3) == 0);
      cmp2_hit = ($urandom_range(0, 3) == 0);
      rollover = ($urandom_range(0, 4) == 0);
      sec_edge = ($urandom_range(0, 4) == 0);
      count_active = $urandom_range(0, 1);
      prim_clk = $urandom_range(0, 1);
      dbg_mode = ($urandom_range(0, 9) == 0);
      dbg_action = 2'($urandom_range(0, 3));
      step("R2-R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule